// File: doc/BRIEF.md
# Byte-Wide Configuration Load Port with Flow Control

This block is the device side of a byte-parallel configuration port. An external loader presents one byte per configuration clock while it holds the active-low select low with the direction input at write. Accepted bytes go into a small internal FIFO. The FIFO is emptied into the configuration buffer at a fixed slow rate: one byte every `DRAIN_DIV` clocks. While the FIFO is full the port raises `busy`, and the loader must keep the same byte on the bus until `busy` falls.

With the direction input at read, the same select reads the buffer back one byte per clock. The port drives the bus one clock after the read request, and its output enable is low at every other time. Once `CFG_BYTES` bytes have reached the buffer, `done` rises. With `persist` low, the port then ignores its select, so devices that share clock, data, direction and `busy` lines can be loaded one after another. With `persist` high, the port stays open for readback after loading.

Top module: `cfg_byte_port`

## Requirements
- R1: A byte on `din` is taken at a rising clock edge only when `cs_n` is 0, `rd_sel` is 0 (write), `busy` is 0, the port is active, and fewer than `CFG_BYTES` bytes have been taken since reset.
- R2: While `cs_n` is 1 the port takes no byte and keeps `dout_oe` at 0.
- R3: The FIFO gives up at most one byte per drain tick. Drain ticks come every `DRAIN_DIV` clocks, counted from reset. Bytes enter the buffer in arrival order at addresses 0, 1, 2 and so on.
- R4: `busy` is 1 exactly when the FIFO holds `DEPTH` bytes. A byte presented while `busy` is 1 is not taken, and the next edge at which `busy` is 0 takes that byte.
- R5: When `cs_n` is 0 and `rd_sel` is 1 (read) at an edge on an active port, `dout_oe` is 1 after that edge and `dout` holds the buffer byte at the read pointer. The read pointer starts at 0 after reset, advances by one on each read edge, and wraps from `CFG_BYTES-1` to 0. Buffer locations not yet written read as 0.
- R6: After any edge without a read request, `dout_oe` is 0 and `dout` is 0.
- R7: `done` becomes 1 in the cycle after the `CFG_BYTES`-th byte is written into the buffer, and stays 1 until reset.
- R8: With `persist` at 0 and `done` at 1, the port takes no writes and gives no readback. With `persist` at 1, readback keeps working after `done`.
- R9: During and straight after reset, `busy`, `done`, `dout_oe` and `dout` are all 0.
- R10: Once `CFG_BYTES` bytes have been taken, further write strobes change nothing, even before `done` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low port select |
| rd_sel | input | 1 | Direction: 1 read, 0 write |
| persist | input | 1 | Keep port active after loading |
| din | input | 8 | Write byte from the loader |
| busy | output | 1 | FIFO full; loader must hold its byte |
| dout | output | 8 | Readback byte |
| dout_oe | output | 1 | Readback bus drive enable |
| done | output | 1 | Configuration buffer complete |

## Verification
Two things can land on the same clock edge. A drain tick can pull a byte out of the full FIFO while the loader is still holding a byte against `busy`. And a readback request can fetch from the buffer at the same edge that a drained byte is written into it. The bench causes the first by writing without gaps, so the FIFO fills and the loader has to hold. It causes the second by switching to readback while the FIFO still holds bytes. A behavioural queue model predicts, for every edge, whether `busy` releases and whether readback returns the byte from before the write. Those predictions are compared with `busy`, `dout` and `dout_oe` on every clock.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
   localparam int BYTE_W = 8;
   typedef logic [BYTE_W-1:0] cfg_byte_t;
endpackage

// File: rtl/cfgp_fifo.sv
module cfgp_fifo
   import cfgp_pkg::*;
#(
   parameter int DEPTH = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push,
   input  cfg_byte_t                  wdata,
   input  logic                       pop,
   output cfg_byte_t                  rdata,
   output logic [$clog2(DEPTH+1)-1:0] level,
   output logic                       full,
   output logic                       empty
);
   localparam int AW = $clog2(DEPTH);
   localparam int LW = $clog2(DEPTH+1);
   localparam logic [AW-1:0] LAST = AW'(DEPTH-1);

   cfg_byte_t     slots [DEPTH];
   logic [AW-1:0] wp, rp;

   assign full  = (level == LW'(DEPTH));
   assign empty = (level == '0);
   assign rdata = slots[rp];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         level <= '0;
      end else begin
         if (push) begin
            slots[wp] <= wdata;
            wp        <= (wp == LAST) ? '0 : wp + 1'b1;
         end
         if (pop)
            rp <= (rp == LAST) ? '0 : rp + 1'b1;
         case ({push, pop})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end
endmodule

// File: rtl/cfgp_drain_timer.sv
module cfgp_drain_timer #(
   parameter int DRAIN_DIV = 3
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   generate
      if (DRAIN_DIV == 1) begin : g_every
         assign tick = 1'b1;
      end else begin : g_count
         localparam int CW = $clog2(DRAIN_DIV);
         localparam logic [CW-1:0] TOP = CW'(DRAIN_DIV-1);
         logic [CW-1:0] cnt;
         assign tick = (cnt == TOP);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt <= '0;
            else        cnt <= tick ? '0 : cnt + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/cfgp_store.sv
module cfgp_store
   import cfgp_pkg::*;
#(
   parameter int CFG_BYTES = 16
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      wr_en,
   input  cfg_byte_t wr_data,
   input  logic      rd_en,
   output cfg_byte_t rd_data,
   output logic      rd_valid,
   output logic      filled
);
   localparam int AW = $clog2(CFG_BYTES);
   localparam int CW = $clog2(CFG_BYTES+1);
   localparam logic [AW-1:0] LAST = AW'(CFG_BYTES-1);

   cfg_byte_t     mem [CFG_BYTES];
   logic [CW-1:0] wr_cnt;
   logic [AW-1:0] rd_ptr;

   assign filled = (wr_cnt == CW'(CFG_BYTES));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < CFG_BYTES; i++) mem[i] <= '0;
         wr_cnt <= '0;
      end else if (wr_en && !filled) begin
         mem[AW'(wr_cnt)] <= wr_data;
         wr_cnt           <= wr_cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr   <= '0;
         rd_data  <= '0;
         rd_valid <= 1'b0;
      end else if (rd_en) begin
         rd_data  <= mem[rd_ptr];
         rd_valid <= 1'b1;
         rd_ptr   <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      end else begin
         rd_data  <= '0;
         rd_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/cfg_byte_port.sv
module cfg_byte_port
   import cfgp_pkg::*;
#(
   parameter int CFG_BYTES = 16,
   parameter int DEPTH     = 4,
   parameter int DRAIN_DIV = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs_n,
   input  logic       rd_sel,
   input  logic       persist,
   input  logic [7:0] din,
   output logic       busy,
   output logic [7:0] dout,
   output logic       dout_oe,
   output logic       done
);
   localparam int LW = $clog2(DEPTH+1);
   localparam int CW = $clog2(CFG_BYTES+1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("cfg_byte_port: DEPTH must be at least 2");
      end
      if (CFG_BYTES < 2) begin : g_bad_bytes
         $error("cfg_byte_port: CFG_BYTES must be at least 2");
      end
      if (DRAIN_DIV < 1) begin : g_bad_div
         $error("cfg_byte_port: DRAIN_DIV must be at least 1");
      end
   endgenerate

   logic          active, sel, accept, drain_tick, fifo_pop;
   logic          fifo_full, fifo_empty;
   logic [LW-1:0] fifo_level;
   cfg_byte_t     fifo_out;
   logic [CW-1:0] taken;

   assign active   = !done || persist;
   assign sel      = active && !cs_n;
   assign busy     = fifo_full;
   assign accept   = sel && !rd_sel && !busy && (taken != CW'(CFG_BYTES));
   assign fifo_pop = drain_tick && !fifo_empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      taken <= '0;
      else if (accept) taken <= taken + 1'b1;
   end

   cfgp_drain_timer #(.DRAIN_DIV(DRAIN_DIV)) u_timer (
      .clk(clk), .rst_n(rst_n), .tick(drain_tick)
   );

   cfgp_fifo #(.DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(accept), .wdata(din),
      .pop(fifo_pop), .rdata(fifo_out), .level(fifo_level),
      .full(fifo_full), .empty(fifo_empty)
   );

   cfgp_store #(.CFG_BYTES(CFG_BYTES)) u_store (
      .clk(clk), .rst_n(rst_n), .wr_en(fifo_pop), .wr_data(fifo_out),
      .rd_en(sel && rd_sel), .rd_data(dout), .rd_valid(dout_oe),
      .filled(done)
   );
endmodule

// File: rtl/cfgp_checker.sv
module cfgp_checker #(
   parameter int DEPTH = 4
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       cs_n,
   input logic                       rd_sel,
   input logic                       persist,
   input logic                       busy,
   input logic                       done,
   input logic                       dout_oe,
   input logic [7:0]                 dout,
   input logic                       tick,
   input logic [$clog2(DEPTH+1)-1:0] level
);
   a_r2_no_take_deselected: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n && !tick) |=> level == $past(level));

   a_r2_no_drive_deselected: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> !dout_oe);

   a_r3_drain_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (level < $past(level)) |-> $past(tick));

   a_r4_busy_means_full: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> level == ($clog2(DEPTH+1))'(DEPTH));

   a_r4_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> level <= $past(level));

   a_r5_drive_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dout_oe) |-> $past(!cs_n && rd_sel));

   a_r6_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
      !dout_oe |-> dout == 8'h00);

   a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> done);

   a_r8_closed_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !persist) |=> !dout_oe);
endmodule

bind cfg_byte_port cfgp_checker #(.DEPTH(DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_sel(rd_sel), .persist(persist),
   .busy(busy), .done(done), .dout_oe(dout_oe), .dout(dout),
   .tick(drain_tick), .level(fifo_level)
);

// File: tb/sim_cfg_byte_port.sv
module sim_cfg_byte_port;
   localparam int CLK_PERIOD = 10;
   localparam int NB  = 16;
   localparam int DEP = 4;
   localparam int DIV = 3;

   logic clk = 0, rst_n = 0, cs_n = 1, rd_sel = 0, persist = 0;
   logic [7:0] din = 0;
   logic busy, dout_oe, done;
   logic [7:0] dout;

   int checks = 0, fails = 0, cycles = 0;
   string phase = "R9";

   cfg_byte_port #(.CFG_BYTES(NB), .DEPTH(DEP), .DRAIN_DIV(DIV)) u0 (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_sel(rd_sel),
      .persist(persist), .din(din), .busy(busy), .dout(dout),
      .dout_oe(dout_oe), .done(done)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // behavioural reference model
   logic [7:0] q[$];
   logic [7:0] m_mem [NB];
   int m_div = 0, m_taken = 0, m_wr = 0, m_rp = 0;
   logic m_oe = 0;
   logic [7:0] m_dout = 0;

   function automatic logic m_busy(); return q.size() == DEP; endfunction
   function automatic logic m_done(); return m_wr == NB; endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q.delete();
         for (int i = 0; i < NB; i++) m_mem[i] = 0;
         m_div = 0; m_taken = 0; m_wr = 0; m_rp = 0; m_oe = 0; m_dout = 0;
      end else begin
         automatic logic act  = !m_done() || persist;
         automatic logic tick = (m_div == DIV-1);
         automatic logic take = act && !cs_n && !rd_sel && !m_busy() && m_taken < NB;
         automatic logic rd   = act && !cs_n && rd_sel;
         if (rd) begin
            m_dout = m_mem[m_rp]; m_oe = 1; m_rp = (m_rp + 1) % NB;
         end else begin
            m_dout = 0; m_oe = 0;
         end
         if (tick && q.size() > 0 && m_wr < NB) begin
            m_mem[m_wr] = q.pop_front(); m_wr++;
         end
         if (take) begin q.push_back(din); m_taken++; end
         m_div = tick ? 0 : m_div + 1;
      end
   end

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s (%s phase %s) actual=%0d expected=%0d", req, what, phase, act, exp);
      end
   endtask

   always @(negedge clk) begin
      cycles++;
      chk("R4", "busy", int'(busy), int'(m_busy()));
      chk("R7", "done", int'(done), int'(m_done()));
      chk("R5", "dout_oe", int'(dout_oe), int'(m_oe));
      chk(m_oe ? "R5" : "R6", "dout", int'(dout), int'(m_dout));
   end

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); cs_n = 1; rd_sel = 0;
      end
   endtask

   // loader: presents byte number m_taken, so it holds while busy
   task automatic load_until(int target, int limit);
      for (int i = 0; i < limit && m_taken < target; i++) begin
         @(negedge clk); cs_n = 0; rd_sel = 0; din = 8'(m_taken * 37 + 5);
      end
   endtask

   task automatic read_n(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); cs_n = 0; rd_sel = 1;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R9: reset state
      chk("R9", "busy at reset", int'(busy), 0);
      chk("R9", "done at reset", int'(done), 0);
      chk("R9", "oe at reset", int'(dout_oe), 0);
      rst_n = 1;
      // R2: deselected writes ignored
      phase = "R2";
      for (int i = 0; i < 8; i++) begin
         @(negedge clk); cs_n = 1; rd_sel = 0; din = 8'hA5;
      end
      @(negedge clk);
      chk("R2", "busy after deselected writes", int'(busy), 0);
      // R1 R4: back-to-back writes fill FIFO, loader holds against busy
      phase = "R1_R4";
      load_until(9, 200);
      // R5 with drain still running: readback concurrent with buffer writes
      phase = "R5";
      read_n(6);
      idle(3);
      // R3 R10: finish load, then extra writes
      phase = "R3_R10";
      load_until(NB, 400);
      for (int i = 0; i < 6; i++) begin
         @(negedge clk); cs_n = 0; rd_sel = 0; din = 8'hEE;
      end
      idle(NB * DIV + 10);
      chk("R7", "done after full load", int'(done), 1);
      // R8: persist off -> port closed
      phase = "R8";
      read_n(5);
      @(negedge clk); cs_n = 1;
      chk("R8", "no readback when closed", int'(dout_oe), 0);
      persist = 1;
      phase = "R8_R5";
      read_n(NB + 5);
      idle(2);
      phase = "R2";
      idle(3);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      fails++;
      $display("FAIL watchdog: run did not end, actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule